// File: doc/BRIEF.md
# Supervisor Trap Sequencer

This block keeps the supervisor-level trap state of a small in-order core and decides, cycle by cycle, whether control must leave the normal instruction stream. Requests come in from the pipeline: a synchronous fault with a cause code and a faulting address, an environment call, two device interrupt lines (timer and external), and a trap-return request. The block also takes the current program counter. When a trap is taken it updates its registers on one clock edge. In the following cycle it raises a single-cycle redirect together with the new fetch address and the new privilege level.

The hardware work on trap entry is deliberately small. It saves only the program counter, masks interrupts, remembers the mode the core was in, writes the cause and, for page faults, the faulting address, and then jumps to the handler base. Everything else is left to software. Software reaches the registers through a simple select/read/write port. That port refuses every access while the core runs in user mode.

Top module: `strap_unit`

## Requirements
- R1: While the status interrupt-enable bit (status bit 1) is 0, a pending timer or external interrupt causes no redirect and leaves every register unchanged. If the line is still high once software sets the bit, the trap is taken.
- R2: Taking any trap clears the status interrupt-enable bit.
- R3: Taking any trap copies the program counter presented in that cycle into the saved-PC register (select 2).
- R4: Taking any trap writes the previous mode into status bit 8, with 0 for user and 1 for supervisor.
- R5: A trap taken at a clock edge drives redirect_o high for exactly the following cycle, with next_pc_o equal to the handler base and priv_o equal to 1 (supervisor). After reset, priv_o is 1 and redirect_o is 0.
- R6: The cause register (select 3) is 64 bits wide, and bit 63 marks an interrupt. An external interrupt writes code 9 and a timer interrupt writes code 5. An environment call writes 8 from user mode and 9 from supervisor mode. A synchronous fault writes its own code.
- R7: A return request in supervisor mode redirects in the next cycle to the saved PC. It sets priv_o from status bit 8 and then resets that bit to 0. A return request in user mode is ignored.
- R8: In user mode any register access raises csr_deny_o, reads return 0, and writes change nothing.
- R9: In supervisor mode the scratch register (select 4) and the saved PC are freely writable and read back. A return lands on the value software last wrote to the saved PC.
- R10: Fault codes 12 (instruction page fault), 13 (load page fault) and 15 (store page fault) write the faulting address into the trap-value register (select 5). Every other trap writes 0 there.
- R11: The handler base register (select 1) always reads back with its two low bits at 0.
- R12: The order of precedence is synchronous fault, then environment call, then external interrupt, then timer interrupt. A trap in the same cycle wins over a return request and over a register write, and that write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | Program counter of the instruction in the trap stage |
| exc_req_i | input | 1 | Synchronous fault request |
| exc_code_i | input | EXC_W | Fault cause code |
| exc_addr_i | input | XLEN | Faulting virtual address |
| ecall_i | input | 1 | Environment call request |
| irq_tmr_i | input | 1 | Timer interrupt level |
| irq_ext_i | input | 1 | External interrupt level |
| sret_i | input | 1 | Return-from-trap request |
| csr_we_i | input | 1 | Register write strobe |
| csr_re_i | input | 1 | Register read strobe |
| csr_sel_i | input | 3 | Register select: 0 status, 1 base, 2 saved PC, 3 cause, 4 scratch, 5 trap value |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data (combinational) |
| csr_deny_o | output | 1 | Access refused (user mode) |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| next_pc_o | output | XLEN | Redirect target |
| priv_o | output | 1 | Current mode, 0 user, 1 supervisor |

## Verification
All register effects and the redirect land one edge after the request. A request driven on a falling edge therefore shows its redirect at the next falling edge. When the driver issues a trap or return, it pushes the target and the mode it expects. A monitor compares redirect_o, next_pc_o and priv_o against the queue head on every falling edge, and any redirect the driver did not expect counts as a failure. Register contents and the deny flag are combinational reads. They are sampled 1 ns after a falling edge, in a cycle with no other request, so they reflect state committed at the preceding rising edge.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic { PRIV_U = 1'b0, PRIV_S = 1'b1 } priv_e;

  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_BASE    = 3'd1,
    SEL_EPC     = 3'd2,
    SEL_CAUSE   = 3'd3,
    SEL_SCRATCH = 3'd4,
    SEL_TVAL    = 3'd5
  } csr_sel_e;

  localparam logic [7:0] CODE_ECALL_U = 8'd8;
  localparam logic [7:0] CODE_ECALL_S = 8'd9;
  localparam logic [7:0] CODE_PF_INST = 8'd12;
  localparam logic [7:0] CODE_PF_LOAD = 8'd13;
  localparam logic [7:0] CODE_PF_STOR = 8'd15;
  localparam logic [7:0] CODE_IRQ_TMR = 8'd5;
  localparam logic [7:0] CODE_IRQ_EXT = 8'd9;

  localparam int ST_IE_BIT  = 1;
  localparam int ST_PRV_BIT = 8;

  function automatic logic is_page_fault(input logic [7:0] code);
    return (code == CODE_PF_INST) || (code == CODE_PF_LOAD) || (code == CODE_PF_STOR);
  endfunction

  function automatic logic [7:0] ecall_code(input priv_e from);
    return (from == PRIV_U) ? CODE_ECALL_U : CODE_ECALL_S;
  endfunction

endpackage

// File: rtl/strap_decide.sv
module strap_decide
  import strap_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int EXC_W = 5
) (
  input  logic             exc_req,
  input  logic [EXC_W-1:0] exc_code,
  input  logic             ecall,
  input  logic             irq_ext,
  input  logic             irq_tmr,
  input  logic             sret,
  input  logic             ie,
  input  priv_e            priv,
  output logic             trap_fire,
  output logic             ret_fire,
  output logic             pf_hit,
  output logic [XLEN-1:0]  cause
);

  localparam int INTR_BIT = XLEN - 1;

  function automatic logic [XLEN-1:0] mk_cause(input logic intr, input logic [7:0] code);
    logic [XLEN-1:0] r;
    r = '0;
    r[7:0] = code;
    r[INTR_BIT] = intr;
    return r;
  endfunction

  logic       irq_live;
  logic [7:0] exc_code8;

  assign exc_code8 = 8'(exc_code);
  assign irq_live  = ie & (irq_ext | irq_tmr);
  assign trap_fire = exc_req | ecall | irq_live;
  assign ret_fire  = sret & ~trap_fire & (priv == PRIV_S);
  assign pf_hit    = exc_req & is_page_fault(exc_code8);

  always_comb begin
    if (exc_req)      cause = mk_cause(1'b0, exc_code8);
    else if (ecall)   cause = mk_cause(1'b0, ecall_code(priv));
    else if (irq_ext) cause = mk_cause(1'b1, CODE_IRQ_EXT);
    else              cause = mk_cause(1'b1, CODE_IRQ_TMR);
  end

endmodule

// File: rtl/strap_csr_file.sv
module strap_csr_file
  import strap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_fire,
  input  logic            ret_fire,
  input  logic            pf_hit,
  input  logic [XLEN-1:0] cause_n,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] fault_addr,
  input  logic            we,
  input  logic            re,
  input  logic [2:0]      sel,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  output logic            deny,
  output logic            wr_ok,
  output priv_e           priv,
  output logic            ie,
  output priv_e           prev,
  output logic [XLEN-1:0] base,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] scratch
);

  localparam logic [XLEN-1:0] BASE_MASK = ~(XLEN'(3));

  logic [XLEN-1:0] cause_q;
  logic [XLEN-1:0] tval_q;
  csr_sel_e        sel_e;

  function automatic logic [XLEN-1:0] pack_status(input logic ie_b, input priv_e pv);
    logic [XLEN-1:0] r;
    r = '0;
    r[ST_IE_BIT]  = ie_b;
    r[ST_PRV_BIT] = pv;
    return r;
  endfunction

  assign sel_e = csr_sel_e'(sel);
  assign wr_ok = we & (priv == PRIV_S) & ~trap_fire;
  assign deny  = (we | re) & (priv == PRIV_U);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv    <= PRIV_S;
      ie      <= 1'b0;
      prev    <= PRIV_U;
      base    <= '0;
      epc     <= '0;
      cause_q <= '0;
      scratch <= '0;
      tval_q  <= '0;
    end else if (trap_fire) begin
      ie      <= 1'b0;
      prev    <= priv;
      priv    <= PRIV_S;
      epc     <= pc;
      cause_q <= cause_n;
      tval_q  <= pf_hit ? fault_addr : '0;
    end else if (ret_fire) begin
      priv <= prev;
      prev <= PRIV_U;
    end else if (wr_ok) begin
      case (sel_e)
        SEL_STATUS: begin
          ie   <= wdata[ST_IE_BIT];
          prev <= priv_e'(wdata[ST_PRV_BIT]);
        end
        SEL_BASE:    base    <= wdata & BASE_MASK;
        SEL_EPC:     epc     <= wdata;
        SEL_CAUSE:   cause_q <= wdata;
        SEL_SCRATCH: scratch <= wdata;
        SEL_TVAL:    tval_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (priv == PRIV_S) begin
      case (sel_e)
        SEL_STATUS:  rdata = pack_status(ie, prev);
        SEL_BASE:    rdata = base;
        SEL_EPC:     rdata = epc;
        SEL_CAUSE:   rdata = cause_q;
        SEL_SCRATCH: rdata = scratch;
        SEL_TVAL:    rdata = tval_q;
        default:     rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/strap_unit.sv
module strap_unit
  import strap_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int EXC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             exc_req_i,
  input  logic [EXC_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]  exc_addr_i,
  input  logic             ecall_i,
  input  logic             irq_tmr_i,
  input  logic             irq_ext_i,
  input  logic             sret_i,
  input  logic             csr_we_i,
  input  logic             csr_re_i,
  input  logic [2:0]       csr_sel_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  csr_rdata_o,
  output logic             csr_deny_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             priv_o
);

  logic            trap_fire;
  logic            ret_fire;
  logic            pf_hit;
  logic            wr_ok;
  logic [XLEN-1:0] cause_n;
  priv_e           cur_priv;
  priv_e           st_prev;
  logic            st_ie;
  logic [XLEN-1:0] base_w;
  logic [XLEN-1:0] epc_w;
  logic [XLEN-1:0] scratch_w;
  logic            redir_q;
  logic [XLEN-1:0] npc_q;

  strap_decide #(.XLEN(XLEN), .EXC_W(EXC_W)) u_decide (
    .exc_req   (exc_req_i),
    .exc_code  (exc_code_i),
    .ecall     (ecall_i),
    .irq_ext   (irq_ext_i),
    .irq_tmr   (irq_tmr_i),
    .sret      (sret_i),
    .ie        (st_ie),
    .priv      (cur_priv),
    .trap_fire (trap_fire),
    .ret_fire  (ret_fire),
    .pf_hit    (pf_hit),
    .cause     (cause_n)
  );

  strap_csr_file #(.XLEN(XLEN)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_fire  (trap_fire),
    .ret_fire   (ret_fire),
    .pf_hit     (pf_hit),
    .cause_n    (cause_n),
    .pc         (pc_i),
    .fault_addr (exc_addr_i),
    .we         (csr_we_i),
    .re         (csr_re_i),
    .sel        (csr_sel_i),
    .wdata      (csr_wdata_i),
    .rdata      (csr_rdata_o),
    .deny       (csr_deny_o),
    .wr_ok      (wr_ok),
    .priv       (cur_priv),
    .ie         (st_ie),
    .prev       (st_prev),
    .base       (base_w),
    .epc        (epc_w),
    .scratch    (scratch_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_q <= 1'b0;
      npc_q   <= '0;
    end else begin
      redir_q <= trap_fire | ret_fire;
      if (trap_fire)     npc_q <= base_w;
      else if (ret_fire) npc_q <= epc_w;
    end
  end

  assign redirect_o = redir_q;
  assign next_pc_o  = npc_q;
  assign priv_o     = cur_priv;

endmodule

// File: rtl/strap_unit_chk.sv
module strap_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pc_i,
  input logic            exc_req_i,
  input logic            ecall_i,
  input logic            sret_i,
  input logic            csr_we_i,
  input logic            csr_re_i,
  input logic            csr_deny_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            priv_o,
  input logic            trap_fire,
  input logic            ret_fire,
  input logic            st_ie,
  input logic            st_prev,
  input logic [XLEN-1:0] base_w,
  input logic [XLEN-1:0] epc_w,
  input logic [XLEN-1:0] scratch_w
);

  AST_IRQ_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_ie && !exc_req_i && !ecall_i && !(sret_i && priv_o)) |=> !redirect_o); // R1

  AST_TRAP_MASKS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> !st_ie); // R2

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (epc_w == $past(pc_i))); // R3

  AST_PREV_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (st_prev == $past(priv_o))); // R4

  AST_ENTRY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (redirect_o && next_pc_o == $past(base_w) && priv_o)); // R5

  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (redirect_o && next_pc_o == $past(epc_w) && priv_o == $past(st_prev))); // R7

  AST_USER_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_o && (csr_we_i || csr_re_i)) |-> csr_deny_o); // R8

  AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_o && csr_we_i) |=> $stable(scratch_w)); // R8

endmodule

bind strap_unit strap_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_i       (pc_i),
  .exc_req_i  (exc_req_i),
  .ecall_i    (ecall_i),
  .sret_i     (sret_i),
  .csr_we_i   (csr_we_i),
  .csr_re_i   (csr_re_i),
  .csr_deny_o (csr_deny_o),
  .redirect_o (redirect_o),
  .next_pc_o  (next_pc_o),
  .priv_o     (priv_o),
  .trap_fire  (trap_fire),
  .ret_fire   (ret_fire),
  .st_ie      (st_ie),
  .st_prev    (st_prev),
  .base_w     (base_w),
  .epc_w      (epc_w),
  .scratch_w  (scratch_w)
);

// File: tb/strap_unit_tb.sv
`timescale 1ns/1ps
module strap_unit_tb;

  localparam int XLEN = 64;
  localparam logic [63:0] BASE = 64'h8000_1000;
  localparam logic [63:0] INTR = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SCR  = 64'hDEAD_BEEF_1234_5678;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [63:0]     pc_i = '0;
  logic            exc_req_i = 1'b0;
  logic [4:0]      exc_code_i = '0;
  logic [63:0]     exc_addr_i = '0;
  logic            ecall_i = 1'b0;
  logic            irq_tmr_i = 1'b0;
  logic            irq_ext_i = 1'b0;
  logic            sret_i = 1'b0;
  logic            csr_we_i = 1'b0;
  logic            csr_re_i = 1'b0;
  logic [2:0]      csr_sel_i = '0;
  logic [63:0]     csr_wdata_i = '0;
  logic [63:0]     csr_rdata_o;
  logic            csr_deny_o;
  logic            redirect_o;
  logic [63:0]     next_pc_o;
  logic            priv_o;

  typedef struct { logic [63:0] pc; logic pv; string tag; } exp_t;
  exp_t expq[$];
  int   checks = 0;
  int   errs = 0;
  logic mon_on = 1'b0;

  always #2.5 clk = ~clk;

  strap_unit #(.XLEN(XLEN), .EXC_W(5)) u_dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_redirect(logic [63:0] pc, logic pv, string tag);
    exp_t e;
    e.pc = pc; e.pv = pv; e.tag = tag;
    expq.push_back(e);
  endtask

  always @(negedge clk) begin
    if (mon_on && redirect_o) begin
      if (expq.size() == 0) begin
        checks++; errs++;
        $display("FAIL R1 unexpected redirect actual=%h expected=none", next_pc_o);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk({e.tag, " redirect target"}, next_pc_o, e.pc);
        chk({e.tag, " mode after redirect"}, 64'(priv_o), 64'(e.pv));
      end
    end
  end

  task automatic finish_op();
    @(posedge clk); #1;
    exc_req_i = 0; ecall_i = 0; irq_tmr_i = 0; irq_ext_i = 0; sret_i = 0;
    csr_we_i = 0; csr_re_i = 0;
  endtask

  task automatic wr(logic [2:0] sel, logic [63:0] d);
    @(negedge clk);
    csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = d;
    finish_op();
  endtask

  task automatic rd(logic [2:0] sel, logic [63:0] exp, string tag);
    @(negedge clk); #1;
    csr_re_i = 1; csr_sel_i = sel; #0.5;
    chk(tag, csr_rdata_o, exp);
    finish_op();
  endtask

  task automatic fault(logic [4:0] code, logic [63:0] addr, logic [63:0] pc, string tag);
    @(negedge clk);
    exc_req_i = 1; exc_code_i = code; exc_addr_i = addr; pc_i = pc;
    expect_redirect(BASE, 1'b1, tag);
    finish_op();
  endtask

  task automatic env_call(logic [63:0] pc, string tag);
    @(negedge clk);
    ecall_i = 1; pc_i = pc;
    expect_redirect(BASE, 1'b1, tag);
    finish_op();
  endtask

  task automatic ret(logic [63:0] tgt, logic pv, string tag);
    @(negedge clk);
    sret_i = 1;
    expect_redirect(tgt, pv, tag);
    finish_op();
  endtask

  initial begin
    #(5.0 * 20000);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R5 reset mode", 64'(priv_o), 64'd1);
    chk("R5 reset redirect", 64'(redirect_o), 64'd0);
    mon_on = 1;

    wr(3'd1, BASE | 64'h3);
    rd(3'd1, BASE, "R11 base low bits");
    wr(3'd4, SCR);
    rd(3'd4, SCR, "R9 scratch readback");

    // R1: external line held while enable is 0
    @(negedge clk);
    irq_ext_i = 1; pc_i = 64'h1000_0040;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1 masked irq no redirect", 64'(redirect_o), 64'd0);
    end
    @(negedge clk); #1;
    csr_re_i = 1; csr_sel_i = 3'd3; #0.5;
    chk("R1 cause untouched", csr_rdata_o, 64'd0);
    @(posedge clk); #1; csr_re_i = 0;
    // enable: trap taken one cycle after the write commits
    @(negedge clk);
    csr_we_i = 1; csr_sel_i = 3'd0; csr_wdata_i = 64'h2;
    @(posedge clk); #1;
    csr_we_i = 0;
    expect_redirect(BASE, 1'b1, "R1 deferred irq");
    @(posedge clk); #1;
    irq_ext_i = 0;
    rd(3'd3, INTR | 64'd9, "R6 external cause");
    rd(3'd0, 64'h100, "R2 R4 status after trap");
    rd(3'd2, 64'h1000_0040, "R3 saved pc");

    // drop to user mode through a return
    wr(3'd0, 64'h0);
    wr(3'd2, 64'h4000);
    ret(64'h4000, 1'b0, "R7 return to user");
    @(negedge clk); #1;
    chk("R7 user mode", 64'(priv_o), 64'd0);

    // R8: user-mode access
    @(negedge clk); #1;
    csr_re_i = 1; csr_sel_i = 3'd4; #0.5;
    chk("R8 user read zero", csr_rdata_o, 64'd0);
    chk("R8 user deny", 64'(csr_deny_o), 64'd1);
    finish_op();
    wr(3'd4, 64'h55);

    env_call(64'h4010, "R6 user ecall");
    rd(3'd4, SCR, "R8 scratch kept after user write");
    rd(3'd3, 64'd8, "R6 ecall from user code");
    rd(3'd0, 64'h0, "R4 previous mode user");
    rd(3'd2, 64'h4010, "R3 ecall saved pc");

    wr(3'd2, 64'h4014);
    ret(64'h4014, 1'b0, "R9 return past ecall");

    // R7: return in user mode ignored
    @(negedge clk);
    sret_i = 1;
    finish_op();
    @(negedge clk); #1;
    chk("R7 user sret ignored", 64'(redirect_o), 64'd0);
    chk("R7 user sret mode", 64'(priv_o), 64'd0);

    // R12: fault beats concurrent ecall and irq
    @(negedge clk);
    exc_req_i = 1; exc_code_i = 5'd13; exc_addr_i = 64'hBAD0; pc_i = 64'h4020;
    ecall_i = 1; irq_ext_i = 1;
    expect_redirect(BASE, 1'b1, "R12 fault first");
    finish_op();
    rd(3'd3, 64'd13, "R12 fault cause wins");
    rd(3'd5, 64'hBAD0, "R10 load fault address");

    env_call(64'h5000, "R6 supervisor ecall");
    rd(3'd3, 64'd9, "R6 ecall from supervisor code");
    rd(3'd5, 64'd0, "R10 non-fault clears value");
    rd(3'd0, 64'h100, "R4 previous mode supervisor");

    fault(5'd15, 64'hC0FFEE, 64'h5100, "R10 store fault");
    rd(3'd5, 64'hC0FFEE, "R10 store fault address");
    fault(5'd12, 64'h7777_0000, 64'h5200, "R10 fetch fault");
    rd(3'd5, 64'h7777_0000, "R10 fetch fault address");
    fault(5'd2, 64'h1234, 64'h5300, "R10 other fault");
    rd(3'd5, 64'd0, "R10 other fault no address");

    // R12: trap beats a register write, external beats timer
    wr(3'd0, 64'h2);
    @(negedge clk);
    irq_ext_i = 1; irq_tmr_i = 1; pc_i = 64'h6000;
    csr_we_i = 1; csr_sel_i = 3'd4; csr_wdata_i = 64'h77;
    expect_redirect(BASE, 1'b1, "R12 irq over write");
    finish_op();
    rd(3'd3, INTR | 64'd9, "R12 external over timer");
    rd(3'd4, SCR, "R12 write dropped");

    // timer alone, with return competing
    wr(3'd0, 64'h2);
    @(negedge clk);
    irq_tmr_i = 1; sret_i = 1; pc_i = 64'h6100;
    expect_redirect(BASE, 1'b1, "R12 trap over return");
    finish_op();
    rd(3'd3, INTR | 64'd5, "R6 timer cause");
    rd(3'd2, 64'h6100, "R3 timer saved pc");

    repeat (4) @(negedge clk);
    chk("R5 all redirects seen", 64'(expq.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule